// File: doc/BRIEF.md
# CAN Message Acceptance Filter Bank

This block decides which receive message center, if any, should store a frame that has just come off the CAN bus. Each frame arrives as one parallel descriptor with a valid strobe. The descriptor carries the format flag (11-bit standard or 29-bit extended), the identifier, the data length code, the first two data bytes and a tag that the receive path uses to find the frame again. The block checks the descriptor against a bank of message centers (fifteen by default). One cycle later it reports the number of the center that accepts the frame, or reports that no center accepts it.

Each center sets its own format, identifier, two data-byte arbitration values and how many leading data bytes take part in the test. It also selects one of two compare styles. The masked style applies the shared identifier mask and the two shared data-byte masks. The exact style compares every relevant bit. Only centers enabled for reception take part. The last center only receives. Its frames do not go into a single slot: the frame tag goes into a small FIFO, and the FIFO keeps a sticky overrun flag for tags that arrive while it is full.

Top module: `can_accept_filter`

## Requirements
- R1: A center matches only a frame whose format flag (`frm_ext`: 0 standard, 1 extended) equals its own `cfg_ext` bit. Standard frames compare identifier bits [10:0] only, so bits [28:11] of `frm_id` have no effect on them.
- R2: Extended frames compare all 29 identifier bits.
- R3: In masked style (`cfg_masked`=1), an identifier bit with `gmask_id` bit 1 must equal the center's identifier bit, and a bit with mask bit 0 is ignored. In exact style every compared identifier bit must match, whatever the masks hold.
- R4: `cfg_nbytes` (0, 1, or 2 and above) gives how many leading data bytes a center tests: byte 0 is `frm_data[7:0]` and byte 1 is `frm_data[15:8]`. Masked style applies `gmask_data` (byte k mask at bits [8k+7:8k]) with the same rule as R3. Exact style requires all 8 bits to be equal.
- R5: A data byte that a center tests but that lies beyond the frame's data length (byte k with `frm_dlc` <= k) is a mismatch.
- R6: A center whose `cfg_rx_en` bit is 0 never accepts a frame.
- R7: When several centers match, the lowest-numbered one is reported. The last center is therefore chosen only when no other center matches.
- R8: The result appears one clock after `frm_valid`: `hit_valid` is high for exactly that cycle. `hit_idx` gives the 1-based center number with `hit_any`=1, or 0 with `hit_any`=0 when nothing matches.
- R9: A frame accepted by the last center pushes its `frm_tag` into a FIFO of `FIFO_DEPTH` (default 4) entries. `fq_tag` shows the oldest entry, and `fq_pop` removes it. Tags leave in arrival order.
- R10: When the FIFO is full, a new tag for the last center is dropped, the stored contents stay the same, and `fq_ovr` sets. `fq_ovr` stays set until `ovr_clr` is pulsed.
- R11: After reset, `hit_valid`, `hit_any`, `hit_idx` and `fq_ovr` are 0, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Frame descriptor valid strobe |
| frm_ext | input | 1 | Frame format: 1 extended, 0 standard |
| frm_id | input | 29 | Frame identifier (standard uses [10:0]) |
| frm_dlc | input | 4 | Frame data length code |
| frm_data | input | 16 | Data byte 0 in [7:0], byte 1 in [15:8] |
| frm_tag | input | TAG_W | Frame tag stored by the last center |
| cfg_rx_en | input | NUM_CENTERS | Per center receive enable (bit c is center c+1) |
| cfg_ext | input | NUM_CENTERS | Per center format |
| cfg_masked | input | NUM_CENTERS | Per center masked (1) or exact (0) style |
| cfg_nbytes | input | 2*NUM_CENTERS | Per center tested byte count, center c at [2c+1:2c] |
| cfg_id | input | 29*NUM_CENTERS | Per center identifier, center c at [29c+28:29c] |
| cfg_arb | input | 16*NUM_CENTERS | Per center byte values, center c at [16c+15:16c] |
| gmask_id | input | 29 | Shared identifier mask |
| gmask_data | input | 16 | Shared data-byte masks |
| fq_pop | input | 1 | Remove the oldest FIFO entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| hit_valid | output | 1 | Result valid |
| hit_any | output | 1 | Some center accepted the frame |
| hit_idx | output | $clog2(NUM_CENTERS+1) | 1-based accepting center, 0 if none |
| fq_tag | output | TAG_W | Oldest FIFO tag |
| fq_empty | output | 1 | FIFO empty |
| fq_full | output | 1 | FIFO full |
| fq_ovr | output | 1 | Sticky overrun flag |

## Verification
The bench targets these cases:
- A standard frame whose upper identifier bits are junk. A filter that compares all 29 bits would miss it.
- An extended frame that carries a standard center's identifier. A filter without the format check would accept it.
- An exact-style center that gets a frame differing only in bits the shared mask ignores. A design that always applies the mask would accept it.
- Data-byte tests that pass on value but fall beyond the data length. Getting these wrong moves frames to the wrong center or accepts them wrongly.
- Overlapping centers, including one that is later disabled. A reversed or broken priority reports the wrong number.
- Six tags sent back to back to the last center. A FIFO that overwrites, loses order or never raises the overrun flag gives the wrong tags on pop.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int ID_W    = 29;
   localparam int STD_W   = 11;
   localparam int NDB     = 2;
   localparam int BYTE_W  = 8;
   localparam int NB_W    = 2;
   localparam int DLC_W   = 4;

   typedef struct packed {
      logic                        ext;
      logic [ID_W-1:0]             id;
      logic [DLC_W-1:0]            dlc;
      logic [NDB-1:0][BYTE_W-1:0]  data;
   } frame_t;
endpackage

// File: rtl/can_center_match.sv
module can_center_match
   import can_filt_pkg::*;
(
   input  frame_t                     frm,
   input  logic                       en,
   input  logic                       ext,
   input  logic                       masked,
   input  logic [NB_W-1:0]            nbytes,
   input  logic [ID_W-1:0]            id,
   input  logic [NDB-1:0][BYTE_W-1:0] arb,
   input  logic [ID_W-1:0]            gm_id,
   input  logic [NDB-1:0][BYTE_W-1:0] gm_byte,
   output logic                       hit
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [ID_W-1:0] STD_SPAN = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};

   logic [ID_W-1:0] span;
   logic [ID_W-1:0] id_care;
   logic            fmt_ok;
   logic            id_ok;
   logic [NDB-1:0]  byte_ok;

   always_comb begin
      span    = frm.ext ? {ID_W{1'b1}} : STD_SPAN;
      id_care = (masked ? gm_id : {ID_W{1'b1}}) & span;
      fmt_ok  = (frm.ext == ext);
      id_ok   = ((frm.id ^ id) & id_care) == '0;
   end

   for (genvar k = 0; k < NDB; k++) begin : g_byte
      logic [BYTE_W-1:0] care;
      logic              tested;
      logic              present;
      always_comb begin
         care       = masked ? gm_byte[k] : {BYTE_W{1'b1}};
         tested     = nbytes > NB_W'(k);
         present    = frm.dlc > DLC_W'(k);
         byte_ok[k] = !tested ||
                      (present && (((frm.data[k] ^ arb[k]) & care) == '0));
      end
   end

   assign hit = en && fmt_ok && id_ok && (&byte_ok);
endmodule

// File: rtl/can_prio_pick.sv
module can_prio_pick #(
   parameter int N     = 15,
   localparam int IDX_W = $clog2(N + 1)
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     gnt,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   timeunit 1ns;
   timeprecision 1ps;

   // lowest bit has the highest priority
   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            gnt[i] = 1'b1;
            idx    = IDX_W'(i + 1);
            any    = 1'b1;
         end
      end
   end

   // R7
   always_comb begin
      one_grant_chk: assert ($onehot0(gnt) && ((gnt & ~req) == '0));
   end
endmodule

// File: rtl/can_tag_fifo.sv
module can_tag_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   input  logic         ovr_clr,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full,
   output logic         ovr
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [CNT_W-1:0] count;
   logic             do_push;
   logic             do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovr    <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         ovr <= (ovr && !ovr_clr) || (push && full);
      end
   end

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R10
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(push && full));

   // R10
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && $stable(dout)));

   // R9
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
   import can_filt_pkg::*;
#(
   parameter int NUM_CENTERS = 15,
   parameter int TAG_W       = 8,
   parameter int FIFO_DEPTH  = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  frm_valid,
   input  logic                                  frm_ext,
   input  logic [ID_W-1:0]                       frm_id,
   input  logic [DLC_W-1:0]                      frm_dlc,
   input  logic [NDB*BYTE_W-1:0]                 frm_data,
   input  logic [TAG_W-1:0]                      frm_tag,
   input  logic [NUM_CENTERS-1:0]                cfg_rx_en,
   input  logic [NUM_CENTERS-1:0]                cfg_ext,
   input  logic [NUM_CENTERS-1:0]                cfg_masked,
   input  logic [NUM_CENTERS*NB_W-1:0]           cfg_nbytes,
   input  logic [NUM_CENTERS*ID_W-1:0]           cfg_id,
   input  logic [NUM_CENTERS*NDB*BYTE_W-1:0]     cfg_arb,
   input  logic [ID_W-1:0]                       gmask_id,
   input  logic [NDB*BYTE_W-1:0]                 gmask_data,
   input  logic                                  fq_pop,
   input  logic                                  ovr_clr,
   output logic                                  hit_valid,
   output logic                                  hit_any,
   output logic [$clog2(NUM_CENTERS+1)-1:0]      hit_idx,
   output logic [TAG_W-1:0]                      fq_tag,
   output logic                                  fq_empty,
   output logic                                  fq_full,
   output logic                                  fq_ovr
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int IDX_W   = $clog2(NUM_CENTERS + 1);
   localparam int ARB_W   = NDB * BYTE_W;
   localparam int FIFO_CN = NUM_CENTERS - 1;

   if (NUM_CENTERS < 2) begin : g_bad_centers
      $error("can_accept_filter: NUM_CENTERS must be at least 2");
   end
   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("can_accept_filter: FIFO_DEPTH must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("can_accept_filter: TAG_W must be at least 1");
   end

   frame_t                   frm;
   logic [NDB-1:0][BYTE_W-1:0] gm_byte;
   logic [NUM_CENTERS-1:0]   match;
   logic [NUM_CENTERS-1:0]   gnt;
   logic [IDX_W-1:0]         pick_idx;
   logic                     pick_any;
   logic                     to_fifo;

   always_comb begin
      frm.ext  = frm_ext;
      frm.id   = frm_id;
      frm.dlc  = frm_dlc;
      frm.data = frm_data;
      gm_byte  = gmask_data;
   end

   for (genvar c = 0; c < NUM_CENTERS; c++) begin : g_center
      logic [NDB-1:0][BYTE_W-1:0] arb_c;
      assign arb_c = cfg_arb[c*ARB_W +: ARB_W];

      can_center_match i_match (
         .frm     (frm),
         .en      (cfg_rx_en[c]),
         .ext     (cfg_ext[c]),
         .masked  (cfg_masked[c]),
         .nbytes  (cfg_nbytes[c*NB_W +: NB_W]),
         .id      (cfg_id[c*ID_W +: ID_W]),
         .arb     (arb_c),
         .gm_id   (gmask_id),
         .gm_byte (gm_byte),
         .hit     (match[c])
      );
   end

   can_prio_pick #(.N(NUM_CENTERS)) i_pick (
      .req (match),
      .gnt (gnt),
      .idx (pick_idx),
      .any (pick_any)
   );

   assign to_fifo = frm_valid && gnt[FIFO_CN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_valid <= 1'b0;
         hit_any   <= 1'b0;
         hit_idx   <= '0;
      end else begin
         hit_valid <= frm_valid;
         hit_any   <= frm_valid && pick_any;
         hit_idx   <= frm_valid ? pick_idx : '0;
      end
   end

   can_tag_fifo #(.W(TAG_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (to_fifo),
      .din     (frm_tag),
      .pop     (fq_pop),
      .ovr_clr (ovr_clr),
      .dout    (fq_tag),
      .empty   (fq_empty),
      .full    (fq_full),
      .ovr     (fq_ovr)
   );

   // R8
   result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> hit_valid);

   // R8
   result_only_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> $past(frm_valid));

   // R8
   idx_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_any == (hit_idx != '0)) && (!hit_any || hit_valid));

   // R6
   disabled_center_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match & ~cfg_rx_en) == '0);
endmodule

// File: tb/test_can_accept_filter.sv
module test_can_accept_filter;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NC = 15;
   localparam int TW = 8;
   localparam int FD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic           frm_valid = 0, frm_ext = 0;
   logic [28:0]    frm_id = '0;
   logic [3:0]     frm_dlc = '0;
   logic [15:0]    frm_data = '0;
   logic [TW-1:0]  frm_tag = '0;
   logic [NC-1:0]  cfg_rx_en, cfg_ext, cfg_masked;
   logic [NC*2-1:0]  cfg_nbytes;
   logic [NC*29-1:0] cfg_id;
   logic [NC*16-1:0] cfg_arb;
   logic [28:0]    gmask_id = 29'h1FFFFF00;
   logic [15:0]    gmask_data = 16'hFFF0;
   logic           fq_pop = 0, ovr_clr = 0;
   logic           hit_valid, hit_any, fq_empty, fq_full, fq_ovr;
   logic [3:0]     hit_idx;
   logic [TW-1:0]  fq_tag;

   // bench-side center configuration (index 0 is center 1)
   logic        c_en [NC];
   logic        c_ext[NC];
   logic        c_msk[NC];
   logic [1:0]  c_nb [NC];
   logic [28:0] c_id [NC];
   logic [7:0]  c_a0 [NC];
   logic [7:0]  c_a1 [NC];

   always_comb begin
      for (int c = 0; c < NC; c++) begin
         cfg_rx_en[c]           = c_en[c];
         cfg_ext[c]             = c_ext[c];
         cfg_masked[c]          = c_msk[c];
         cfg_nbytes[c*2 +: 2]   = c_nb[c];
         cfg_id[c*29 +: 29]     = c_id[c];
         cfg_arb[c*16 +: 16]    = {c_a1[c], c_a0[c]};
      end
   end

   can_accept_filter #(.NUM_CENTERS(NC), .TAG_W(TW), .FIFO_DEPTH(FD)) i_can_accept_filter (
      .clk, .rst_n, .frm_valid, .frm_ext, .frm_id, .frm_dlc, .frm_data, .frm_tag,
      .cfg_rx_en, .cfg_ext, .cfg_masked, .cfg_nbytes, .cfg_id, .cfg_arb,
      .gmask_id, .gmask_data, .fq_pop, .ovr_clr,
      .hit_valid, .hit_any, .hit_idx, .fq_tag, .fq_empty, .fq_full, .fq_ovr
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int    q_idx[$];
   string q_req[$];
   int    fm[$];
   bit    ovr_m = 0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // requirement model of one center
   function automatic bit center_ok(int c, bit ext, logic [28:0] id, int dlc,
                                    logic [7:0] b0, logic [7:0] b1);
      logic [28:0] m;
      logic [7:0]  m0, m1;
      if (!c_en[c] || ext != c_ext[c]) return 0;
      m = c_msk[c] ? gmask_id : 29'h1FFFFFFF;
      if (!ext) m = m & 29'h7FF;
      if (((id ^ c_id[c]) & m) != 0) return 0;
      m0 = c_msk[c] ? gmask_data[7:0]  : 8'hFF;
      m1 = c_msk[c] ? gmask_data[15:8] : 8'hFF;
      if (c_nb[c] >= 1 && (dlc < 1 || ((b0 ^ c_a0[c]) & m0) != 0)) return 0;
      if (c_nb[c] >= 2 && (dlc < 2 || ((b1 ^ c_a1[c]) & m1) != 0)) return 0;
      return 1;
   endfunction

   function automatic int model_pick(bit ext, logic [28:0] id, int dlc,
                                     logic [7:0] b0, logic [7:0] b1);
      for (int c = 0; c < NC; c++)
         if (center_ok(c, ext, id, dlc, b0, b1)) return c + 1;
      return 0;
   endfunction

   // driver: presents one frame for one cycle, queues the expected result
   task automatic send(bit ext, logic [28:0] id, int dlc, logic [7:0] b0,
                       logic [7:0] b1, logic [TW-1:0] tag, int exp, string req);
      int m;
      @(negedge clk);
      m = model_pick(ext, id, dlc, b0, b1);
      check(m == exp, req, "model vs plan", m, exp);
      frm_valid = 1; frm_ext = ext; frm_id = id; frm_dlc = 4'(dlc);
      frm_data = {b1, b0}; frm_tag = tag;
      q_idx.push_back(m); q_req.push_back(req);
      if (m == NC) begin
         if (fm.size() < FD) fm.push_back(int'(tag));
         else ovr_m = 1;
      end
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         frm_valid = 0;
      end
   endtask

   // monitor: compares every result against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && hit_valid) begin
            if (q_idx.size() == 0) begin
               check(0, "R8", "unexpected hit_valid", 1, 0);
            end else begin
               int e; string r;
               e = q_idx.pop_front(); r = q_req.pop_front();
               check(int'(hit_idx) == e, r, "hit_idx", int'(hit_idx), e);
               check(hit_any == (e != 0), r, "hit_any", int'(hit_any), int'(e != 0));
            end
         end
      end
   end

   task automatic check_fifo(string req);
      check(fq_empty == (fm.size() == 0), req, "fq_empty", int'(fq_empty), int'(fm.size() == 0));
      check(fq_full == (fm.size() == FD), req, "fq_full", int'(fq_full), int'(fm.size() == FD));
      check(fq_ovr == ovr_m, req, "fq_ovr", int'(fq_ovr), int'(ovr_m));
      if (fm.size() != 0) check(int'(fq_tag) == fm[0], req, "fq_tag", int'(fq_tag), fm[0]);
   endtask

   task automatic pop_one(string req);
      @(negedge clk);
      check_fifo(req);
      fq_pop = 1;
      @(negedge clk);
      fq_pop = 0;
      if (fm.size() != 0) void'(fm.pop_front());
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NC; c++) begin
         c_en[c] = 0; c_ext[c] = 0; c_msk[c] = 0; c_nb[c] = 0;
         c_id[c] = '0; c_a0[c] = '0; c_a1[c] = '0;
      end
      c_en[0]  = 1; c_id[0]  = 29'h123;
      c_en[1]  = 1; c_ext[1] = 1; c_msk[1] = 1; c_id[1] = 29'h1ABCDEF0;
      c_en[2]  = 1; c_ext[2] = 1; c_id[2]  = 29'h456;
      c_en[3]  = 1; c_msk[3] = 1; c_nb[3]  = 2; c_id[3] = 29'h055; c_a0[3] = 8'hA5; c_a1[3] = 8'h3C;
      c_en[4]  = 1; c_nb[4]  = 1; c_id[4]  = 29'h055; c_a0[4] = 8'hA9;
      c_en[5]  = 1; c_id[5]  = 29'h200;
      c_en[6]  = 1; c_id[6]  = 29'h200;
      c_id[7]  = 29'h300;
      c_en[13] = 1; c_id[13] = 29'h7AA;
      c_en[14] = 1; c_msk[14] = 1; c_id[14] = 29'h700;

      repeat (3) @(negedge clk);
      // R11 reset state
      check(hit_valid == 0 && hit_any == 0 && hit_idx == 0, "R11", "result regs", int'(hit_idx), 0);
      check(fq_empty == 1 && fq_ovr == 0, "R11", "fifo reset", int'(fq_ovr), 0);
      rst_n = 1;
      idle(2);

      send(0, 29'h123,      0, 8'h00, 8'h00, 8'h00, 1,  "R1");
      send(0, 29'h1FFFF923, 0, 8'h00, 8'h00, 8'h00, 1,  "R1");
      send(1, 29'h123,      0, 8'h00, 8'h00, 8'h00, 0,  "R1");
      send(1, 29'h1ABCDE55, 0, 8'h00, 8'h00, 8'h00, 2,  "R3");
      send(1, 29'h1ABCDF55, 0, 8'h00, 8'h00, 8'h00, 0,  "R2");
      send(1, 29'h456,      0, 8'h00, 8'h00, 8'h00, 3,  "R2");
      send(1, 29'h10000456, 0, 8'h00, 8'h00, 8'h00, 0,  "R2");
      send(1, 29'h457,      0, 8'h00, 8'h00, 8'h00, 0,  "R3");
      send(0, 29'h055,      2, 8'hA9, 8'h3C, 8'h00, 4,  "R4");
      send(0, 29'h0FF,      2, 8'hA9, 8'h3C, 8'h00, 4,  "R3");
      send(0, 29'h055,      2, 8'hA9, 8'h3D, 8'h00, 5,  "R4");
      send(0, 29'h055,      2, 8'hB9, 8'h3C, 8'h00, 0,  "R4");
      send(0, 29'h055,      1, 8'hA9, 8'h3C, 8'h00, 5,  "R5");
      send(0, 29'h055,      0, 8'hA9, 8'h3C, 8'h00, 0,  "R5");
      send(0, 29'h200,      0, 8'h00, 8'h00, 8'h00, 6,  "R7");
      send(0, 29'h7AA,      0, 8'h00, 8'h00, 8'h00, 14, "R7");
      send(0, 29'h300,      0, 8'h00, 8'h00, 8'h00, 0,  "R6");
      idle(1);
      c_en[5] = 0;
      send(0, 29'h200,      0, 8'h00, 8'h00, 8'h00, 7,  "R6");
      idle(2);
      // R8: no result without a frame
      check(hit_valid == 0, "R8", "hit_valid idle", int'(hit_valid), 0);

      // R9 / R10: last center and its FIFO
      send(0, 29'h701, 0, 8'h00, 8'h00, 8'h11, 15, "R9");
      send(0, 29'h702, 0, 8'h00, 8'h00, 8'h12, 15, "R9");
      idle(2);
      check_fifo("R9");
      send(0, 29'h703, 0, 8'h00, 8'h00, 8'h13, 15, "R9");
      send(0, 29'h704, 0, 8'h00, 8'h00, 8'h14, 15, "R9");
      send(0, 29'h705, 0, 8'h00, 8'h00, 8'h15, 15, "R10");
      send(0, 29'h706, 0, 8'h00, 8'h00, 8'h16, 15, "R10");
      idle(2);
      check_fifo("R10");
      check(fq_ovr == 1, "R10", "overrun set", int'(fq_ovr), 1);
      for (int i = 0; i < FD; i++) pop_one("R9");
      idle(1);
      check_fifo("R9");
      check(fq_ovr == 1, "R10", "overrun sticky", int'(fq_ovr), 1);
      @(negedge clk); ovr_clr = 1;
      @(negedge clk); ovr_clr = 0; ovr_m = 0;
      check_fifo("R10");

      idle(3);
      check(q_idx.size() == 0, "R8", "results outstanding", q_idx.size(), 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule